// File: doc/BRIEF.md
# Transmit DMA Channel Control and Error Monitor

This block holds the control and status registers for a group of transmit DMA channels (eight by default). Each channel has a configuration word carrying a two-bit run mode and a request-enable bit. Each channel also has a saturating credit counter that transmit-FIFO credit returns raise and credit consumption lowers. From these and from per-channel activity inputs, the block decides whether each channel may take new work. A channel can be stopped at once, or it can be parked cleanly once its current work has drained.

A shared status word reports two flags per channel: buffers empty and no request pending. A sticky error word collects several faults. One is a FIFO-full indication arriving while the channel still holds credit. Another is a new command arriving while the channel's single command slot is still occupied. The rest are two chip-level faults: an internal-memory address error and a short host transfer. Software reads and writes everything through a simple register port with one cycle of read latency, and clears error bits by writing ones.

Top module: `txmon_top`

## Requirements
- R1: Channel n's configuration word is at byte address n*0x20. A write stores bits 31:30 (mode) and bit 3 (request enable). A read returns those bits and zero in every other position.
- R2: With mode 2'b10 (run) and bit 3 set, ch_go[n] is 1. With bit 3 clear, ch_go[n] is 0 whatever the mode.
- R3: Mode 2'b00 (off) and mode 2'b11 (reserved) drive ch_go[n] to 0 from the cycle after the write.
- R4: Mode 2'b01 (park) with bit 3 set keeps ch_go[n] at 1 while the channel is busy. ch_go[n] drops as soon as ch_idle[n] is 1, and it stays 0 even if the channel becomes busy again, until the configuration word is written again.
- R5: The status word at 0x100 holds buf_empty in bits 31:24 and no_pend in bits 23:16, with bit 24+n and bit 16+n belonging to channel n. Other bits read 0. ch_idle[n] is 1 only when both of channel n's flags are 1.
- R6: The credit counter of channel n reads at n*0x20+4, zero-extended. It resets to 0, rises by one on credit_ret[n] and falls by one on credit_use[n]. It holds when both arrive together, holds at 0 on a decrement, and holds at its maximum (255 by default) on an increment.
- R7: Error bit n (n = 0..7) sets when fifo_full[n] is 1 while channel n's credit counter is nonzero and its bit 3 is set. A zero counter, or a clear bit 3, sets nothing.
- R8: Error bit 9+n sets when cmd_arrive[n] comes while channel n's command slot is occupied and cmd_take[n] is not 1 in the same cycle. cmd_arrive fills the slot and cmd_take empties it.
- R9: Error bit 31 sets on mem_addr_err and error bit 30 sets on short_xfer.
- R10: The error word at 0x104 is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as a clear of that bit leaves the bit set.
- R11: After reset, all configuration words, credits and error bits are 0, ch_go is 0, err_any is 0 and rd_data is 0.
- R12: err_any is 1 exactly when some error bit is set.
- R13: rd_data shows the addressed word in the cycle after rd_en and holds its value while rd_en is 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 9 | Register read byte address |
| rd_data | output | 32 | Registered read data |
| buf_empty | input | 8 | Per-channel buffers-empty flag |
| no_pend | input | 8 | Per-channel no-request-pending flag |
| fifo_full | input | 8 | Per-channel transmit FIFO full |
| credit_ret | input | 8 | Per-channel credit return pulse |
| credit_use | input | 8 | Per-channel credit consume pulse |
| cmd_arrive | input | 8 | Per-channel command arrival pulse |
| cmd_take | input | 8 | Per-channel command slot drained pulse |
| mem_addr_err | input | 1 | Internal memory address fault pulse |
| short_xfer | input | 1 | Short host transfer fault pulse |
| ch_go | output | 8 | Per-channel permission to take new work |
| ch_idle | output | 8 | Per-channel idle (both flags set) |
| err_any | output | 1 | OR of all error bits |

## Verification
A wrong mode or request-enable bit shows on ch_go one cycle after the configuration write. A lost park latch shows as ch_go returning high once the channel becomes busy again. A wrong credit count cannot be seen directly on the outputs. It appears when the counter is read back, one cycle after the read strobe, or indirectly when a FIFO-full event sets or fails to set its error bit. A wrong command-slot occupancy or a lost sticky bit shows on err_any in the cycle after the event.

// File: rtl/txmon_pkg.sv
package txmon_pkg;
    localparam int ADDR_W      = 9;
    localparam int DATA_W      = 32;
    localparam int CH_STRIDE   = 32;
    localparam int CREDIT_OFF  = 4;
    localparam int STATUS_ADDR = 'h100;
    localparam int ERR_ADDR    = 'h104;
    localparam int OVF_LSB     = 9;
    localparam int BUSY_LSB    = 16;
    localparam int EMPTY_LSB   = 24;
    localparam int MEMERR_BIT  = 31;
    localparam int SHORT_BIT   = 30;
    localparam int REQ_BIT     = 3;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_PARK = 2'b01,
        MODE_RUN  = 2'b10,
        MODE_RSV  = 2'b11
    } run_mode_e;
endpackage

// File: rtl/txmon_chan.sv
module txmon_chan
    import txmon_pkg::*;
#(
    parameter int CRD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_req,
    input  logic             credit_ret,
    input  logic             credit_use,
    input  logic             fifo_full,
    input  logic             buf_empty,
    input  logic             no_pend,
    input  logic             cmd_arrive,
    input  logic             cmd_take,
    output logic [1:0]       mode_o,
    output logic             req_o,
    output logic [CRD_W-1:0] credit_o,
    output logic             go,
    output logic             idle,
    output logic             credit_err,
    output logic             cmd_ovf
);
    localparam logic [CRD_W-1:0] CRD_MAX = {CRD_W{1'b1}};

    typedef struct packed {
        run_mode_e        mode;
        logic             req;
        logic [CRD_W-1:0] credit;
        logic             occ;
        logic             parked;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.mode   = run_mode_e'(cfg_mode);
            st_d.req    = cfg_req;
            st_d.parked = 1'b0;
        end else if (st_q.mode == MODE_PARK && idle) begin
            st_d.parked = 1'b1;
        end
        case ({credit_ret, credit_use})
            2'b10:   if (st_q.credit != CRD_MAX) st_d.credit = st_q.credit + 1'b1;
            2'b01:   if (st_q.credit != '0)      st_d.credit = st_q.credit - 1'b1;
            default: st_d.credit = st_q.credit;
        endcase
        st_d.occ = cmd_arrive | (st_q.occ & ~cmd_take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle       = buf_empty & no_pend;
    assign go         = st_q.req &&
                        (st_q.mode == MODE_RUN ||
                         (st_q.mode == MODE_PARK && !st_q.parked && !idle));
    assign credit_err = fifo_full && st_q.req && (st_q.credit != '0);
    assign cmd_ovf    = cmd_arrive && st_q.occ && !cmd_take;
    assign mode_o     = st_q.mode;
    assign req_o      = st_q.req;
    assign credit_o   = st_q.credit;
endmodule

// File: rtl/txmon_errreg.sv
module txmon_errreg
    import txmon_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] err_o
);
    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } err_st_t;

    err_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = ((st_q.bits & ~clr_vec) | set_vec) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.bits;
endmodule

// File: rtl/txmon_top.sv
module txmon_top
    import txmon_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CRD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [8:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [8:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NUM_CH-1:0] buf_empty,
    input  logic [NUM_CH-1:0] no_pend,
    input  logic [NUM_CH-1:0] fifo_full,
    input  logic [NUM_CH-1:0] credit_ret,
    input  logic [NUM_CH-1:0] credit_use,
    input  logic [NUM_CH-1:0] cmd_arrive,
    input  logic [NUM_CH-1:0] cmd_take,
    input  logic              mem_addr_err,
    input  logic              short_xfer,
    output logic [NUM_CH-1:0] ch_go,
    output logic [NUM_CH-1:0] ch_idle,
    output logic              err_any
);
    localparam int PAD_W = DATA_W - CRD_W;

    function automatic logic [DATA_W-1:0] impl_mask_f();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            m[n]           = 1'b1;
            m[OVF_LSB + n] = 1'b1;
        end
        m[MEMERR_BIT] = 1'b1;
        m[SHORT_BIT]  = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] IMPL_MASK = impl_mask_f();

    logic [NUM_CH-1:0]       cfg_we;
    logic [1:0]              mode_v   [NUM_CH];
    logic [NUM_CH-1:0]       req_v;
    logic [CRD_W-1:0]        credit_v [NUM_CH];
    logic [NUM_CH-1:0]       crd_err_v;
    logic [NUM_CH-1:0]       ovf_v;
    logic [DATA_W-1:0]       set_vec;
    logic [DATA_W-1:0]       clr_vec;
    logic [DATA_W-1:0]       err_vec;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            assign cfg_we[g] = wr_en && (wr_addr == ADDR_W'(g * CH_STRIDE));

            txmon_chan #(.CRD_W(CRD_W)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg_we     (cfg_we[g]),
                .cfg_mode   (wr_data[31:30]),
                .cfg_req    (wr_data[REQ_BIT]),
                .credit_ret (credit_ret[g]),
                .credit_use (credit_use[g]),
                .fifo_full  (fifo_full[g]),
                .buf_empty  (buf_empty[g]),
                .no_pend    (no_pend[g]),
                .cmd_arrive (cmd_arrive[g]),
                .cmd_take   (cmd_take[g]),
                .mode_o     (mode_v[g]),
                .req_o      (req_v[g]),
                .credit_o   (credit_v[g]),
                .go         (ch_go[g]),
                .idle       (ch_idle[g]),
                .credit_err (crd_err_v[g]),
                .cmd_ovf    (ovf_v[g])
            );
        end
    endgenerate

    always_comb begin
        set_vec = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            set_vec[n]           = crd_err_v[n];
            set_vec[OVF_LSB + n] = ovf_v[n];
        end
        set_vec[MEMERR_BIT] = mem_addr_err;
        set_vec[SHORT_BIT]  = short_xfer;
        clr_vec = (wr_en && wr_addr == ADDR_W'(ERR_ADDR)) ? wr_data : '0;
    end

    txmon_errreg #(.IMPL_MASK(IMPL_MASK)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .err_o   (err_vec)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.rdata = '0;
            for (int n = 0; n < NUM_CH; n++) begin
                if (rd_addr == ADDR_W'(n * CH_STRIDE)) begin
                    rd_d.rdata[31:30]   = mode_v[n];
                    rd_d.rdata[REQ_BIT] = req_v[n];
                end
                if (rd_addr == ADDR_W'(n * CH_STRIDE + CREDIT_OFF))
                    rd_d.rdata = {{PAD_W{1'b0}}, credit_v[n]};
            end
            if (rd_addr == ADDR_W'(STATUS_ADDR)) begin
                for (int n = 0; n < NUM_CH; n++) begin
                    rd_d.rdata[EMPTY_LSB + n] = buf_empty[n];
                    rd_d.rdata[BUSY_LSB + n]  = no_pend[n];
                end
            end
            if (rd_addr == ADDR_W'(ERR_ADDR))
                rd_d.rdata = err_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.rdata;
    assign err_any = |err_vec;
endmodule

// File: rtl/txmon_chk.sv
module txmon_chk
    import txmon_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [8:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              mem_addr_err,
    input logic              short_xfer,
    input logic [NUM_CH-1:0] ch_go,
    input logic [31:0]       err_vec
);
    logic [31:0] clr_w;
    assign clr_w = (wr_en && wr_addr == ADDR_W'(ERR_ADDR)) ? wr_data : '0;

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vec != 0) |=> (($past(err_vec) & ~$past(clr_w) & ~err_vec) == 0));

    p_memerr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_err |=> err_vec[MEMERR_BIT]);

    p_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        short_xfer |=> err_vec[SHORT_BIT]);

    p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chk
            p_go_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(g * CH_STRIDE) &&
                 (wr_data[31:30] == 2'b00 || wr_data[31:30] == 2'b11))
                |=> !ch_go[g]);

            p_go_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(g * CH_STRIDE) && !wr_data[REQ_BIT])
                |=> !ch_go[g]);
        end
    endgenerate
endmodule

bind txmon_top txmon_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .mem_addr_err (mem_addr_err),
    .short_xfer   (short_xfer),
    .ch_go        (ch_go),
    .err_vec      (err_vec)
);

// File: tb/sim_txmon_top.sv
module sim_txmon_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  buf_empty = 8'hFF;
    logic [7:0]  no_pend = 8'hFF;
    logic [7:0]  fifo_full = '0;
    logic [7:0]  credit_ret = '0;
    logic [7:0]  credit_use = '0;
    logic [7:0]  cmd_arrive = '0;
    logic [7:0]  cmd_take = '0;
    logic        mem_addr_err = 1'b0;
    logic        short_xfer = 1'b0;
    logic [7:0]  ch_go;
    logic [7:0]  ch_idle;
    logic        err_any;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    txmon_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_empty(buf_empty), .no_pend(no_pend), .fifo_full(fifo_full),
        .credit_ret(credit_ret), .credit_use(credit_use),
        .cmd_arrive(cmd_arrive), .cmd_take(cmd_take),
        .mem_addr_err(mem_addr_err), .short_xfer(short_xfer),
        .ch_go(ch_go), .ch_idle(ch_idle), .err_any(err_any)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // sel: 0 credit_ret, 1 credit_use, 2 fifo_full, 3 cmd_arrive, 4 cmd_take
    task automatic pulse(input int sel, input logic [7:0] v);
        @(negedge clk);
        case (sel)
            0: credit_ret = v;
            1: credit_use = v;
            2: fifo_full  = v;
            3: cmd_arrive = v;
            default: cmd_take = v;
        endcase
        @(negedge clk);
        credit_ret = '0; credit_use = '0; fifo_full = '0;
        cmd_arrive = '0; cmd_take = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R11 rd_data", rd_data, 32'h0);
        check("R11 ch_go", {24'h0, ch_go}, 32'h0);
        check("R11 err_any", {31'h0, err_any}, 32'h0);
        reg_rd(9'h040, d);
        check("R11 cfg2", d, 32'h0);
        reg_rd(9'h104, d);
        check("R11 err", d, 32'h0);
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        reg_wr(9'h060, 32'hFFFF_FFFF);
        reg_rd(9'h060, d);
        check("R1 cfg3 readback", d, 32'hC000_0008);
        check("R3 reserved mode go", {31'h0, ch_go[3]}, 32'h0);
        reg_wr(9'h060, 32'h0);
        reg_rd(9'h060, d);
        check("R1 cfg3 cleared", d, 32'h0);
        reg_rd(9'h064 + 9'h008, d);
        check("R13 unmapped", d, 32'h0);
    endtask

    task automatic t_run();
        reg_wr(9'h000, 32'h8000_0008);
        check("R2 run go", {31'h0, ch_go[0]}, 32'h1);
        reg_wr(9'h000, 32'h8000_0000);
        check("R2 no req go", {31'h0, ch_go[0]}, 32'h0);
        reg_wr(9'h000, 32'h8000_0008);
        reg_wr(9'h000, 32'h0000_0008);
        check("R3 off go", {31'h0, ch_go[0]}, 32'h0);
    endtask

    task automatic t_park();
        @(negedge clk);
        buf_empty[1] = 1'b0;
        reg_wr(9'h020, 32'h4000_0008);
        check("R4 park busy go", {31'h0, ch_go[1]}, 32'h1);
        @(negedge clk);
        buf_empty[1] = 1'b1;
        #1;
        check("R4 park idle go", {31'h0, ch_go[1]}, 32'h0);
        @(negedge clk);
        @(negedge clk);
        no_pend[1] = 1'b0;
        #1;
        check("R4 parked stays", {31'h0, ch_go[1]}, 32'h0);
        reg_wr(9'h020, 32'h4000_0008);
        check("R4 rewrite go", {31'h0, ch_go[1]}, 32'h1);
        @(negedge clk);
        no_pend[1] = 1'b1;
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk);
        buf_empty = 8'hA5; no_pend = 8'h3C;
        reg_rd(9'h100, d);
        check("R5 status", d, 32'hA53C_0000);
        check("R5 idle", {24'h0, ch_idle}, 32'h0000_0024);
        @(negedge clk);
        buf_empty = 8'hFF; no_pend = 8'hFF;
    endtask

    task automatic t_credit();
        logic [31:0] d;
        pulse(1, 8'h08);
        reg_rd(9'h064, d);
        check("R6 underflow hold", d, 32'h0);
        @(negedge clk);
        credit_ret[3] = 1'b1;
        repeat (300) @(negedge clk);
        credit_ret[3] = 1'b0;
        reg_rd(9'h064, d);
        check("R6 saturate", d, 32'd255);
        @(negedge clk);
        credit_ret[3] = 1'b1; credit_use[3] = 1'b1;
        @(negedge clk);
        credit_ret[3] = 1'b0; credit_use[3] = 1'b0;
        reg_rd(9'h064, d);
        check("R6 both hold", d, 32'd255);
        pulse(1, 8'h08);
        reg_rd(9'h064, d);
        check("R6 decrement", d, 32'd254);
    endtask

    task automatic t_crd_err();
        logic [31:0] d;
        reg_wr(9'h040, 32'h8000_0008);
        reg_wr(9'h080, 32'h8000_0008);
        pulse(0, 8'h80);
        repeat (3) pulse(0, 8'h04);
        reg_rd(9'h044, d);
        check("R6 count three", d, 32'd3);
        pulse(2, 8'h94);
        reg_rd(9'h104, d);
        check("R7 credit error only ch2", d, 32'h0000_0004);
        check("R12 err_any set", {31'h0, err_any}, 32'h1);
    endtask

    task automatic t_cmd();
        logic [31:0] d;
        pulse(3, 8'h40);
        @(negedge clk);
        cmd_arrive[6] = 1'b1; cmd_take[6] = 1'b1;
        @(negedge clk);
        cmd_arrive = '0; cmd_take = '0;
        pulse(3, 8'h20);
        reg_rd(9'h104, d);
        check("R8 first arrivals clean", d, 32'h0000_0004);
        pulse(3, 8'h20);
        reg_rd(9'h104, d);
        check("R8 overflow ch5", d, 32'h0000_4004);
    endtask

    task automatic t_fault();
        logic [31:0] d;
        @(negedge clk);
        mem_addr_err = 1'b1;
        @(negedge clk);
        mem_addr_err = 1'b0; short_xfer = 1'b1;
        @(negedge clk);
        short_xfer = 1'b0;
        reg_rd(9'h104, d);
        check("R9 fault bits", d, 32'hC000_4004);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        reg_wr(9'h104, 32'h0);
        reg_rd(9'h104, d);
        check("R10 write zero", d, 32'hC000_4004);
        reg_wr(9'h104, 32'h8000_0000);
        reg_rd(9'h104, d);
        check("R10 clear bit31", d, 32'h4000_4004);
        @(negedge clk);
        fifo_full[2] = 1'b1; wr_en = 1'b1; wr_addr = 9'h104; wr_data = 32'h4;
        @(negedge clk);
        fifo_full[2] = 1'b0; wr_en = 1'b0;
        reg_rd(9'h104, d);
        check("R10 set wins", d, 32'h4000_4004);
        reg_wr(9'h104, 32'hFFFF_FFFF);
        reg_rd(9'h104, d);
        check("R10 clear all", d, 32'h0);
        check("R12 err_any clear", {31'h0, err_any}, 32'h0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        reg_rd(9'h000, d);
        check("R13 read cfg0", d, 32'h0000_0008);
        @(negedge clk);
        rd_addr = 9'h044;
        @(negedge clk);
        check("R13 hold", rd_data, 32'h0000_0008);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_run();
        t_park();
        t_status();
        t_credit();
        t_crd_err();
        t_cmd();
        t_fault();
        t_clear();
        t_latency();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule